// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a last-in, first-out store of `DEPTH` words, each `WIDTH` bits wide. The words sit in a chain of word-wide register stages. Stage 0 always holds the top of the stack, so the top word can be read without any address decoding. A small controller decides each cycle whether the chain holds, moves one stage deeper, moves one stage toward the top, or writes a new word into stage 0.

A push opens the top slot and then fills it, so it takes two cycles and the block reports itself busy while it runs. A pop finishes in a single cycle. The word on the top-of-stack output in the cycle a pop is accepted is the word removed. An occupancy count drives the full and empty flags. A request the stack cannot honour raises a one-cycle error pulse and leaves the contents as they were.

Top module: `stk_lifo`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full`, `busy` and `err` are 0, and `top_data` is zero.
- R2: Words are returned in last-in, first-out order. The value on `top_data` in the cycle a pop is accepted is the most recently pushed word still held.
- R3: An accepted push (`push_req` high while idle and not full) holds `busy` high for exactly the two following cycles. After those two cycles `top_data` equals the word that was on `push_data` when the push was accepted.
- R4: While `busy` is 1, `push_req` and `pop_req` are ignored: stack contents, occupancy and `err` are unaffected.
- R5: An accepted pop (`pop_req` high, `push_req` low, idle, not empty) takes one cycle. Every word moves one stage toward the top and the deepest stage fills with zero, so after the last word is popped `top_data` reads zero.
- R6: `full` is 1 exactly when `DEPTH` words are held, and `empty` is 1 exactly when none are held.
- R7: A push requested while idle and full is rejected: contents and flags are unchanged, `busy` stays 0, and `err` is 1 for the next cycle only.
- R8: A pop requested while idle and empty, with no push request, is rejected: the stack stays empty and `err` is 1 for the next cycle only.
- R9: When `push_req` and `pop_req` are both high while idle, the push is performed and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to remove the top word |
| push_data | input | WIDTH | Word to push |
| top_data | output | WIDTH | Current word in stage 0 |
| full | output | 1 | Stack holds DEPTH words |
| empty | output | 1 | Stack holds no words |
| busy | output | 1 | Push sequence in progress; requests ignored |
| err | output | 1 | One-cycle pulse after a rejected request |

## Verification
Directed runs push a short run of distinct words and pop them back, which shows whether the order is reversed or kept. The stack is filled to capacity and drained, which exercises both flag thresholds, the zero fill at the bottom and the rejection at each end. Requests are driven during the busy window and push is raised together with pop, which shows whether the controller lets a second operation in or picks the wrong one. A long stretch of random requests is then compared clock by clock against a queue-based model. This shows up off-by-one timing in the push sequence or in the error pulse.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } ctrl_state_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_DEEPER = 2'd1,
        OP_UPWARD = 2'd2,
        OP_LOAD   = 2'd3
    } chain_op_t;

    function automatic logic state_is_busy(ctrl_state_t s);
        return (s != ST_IDLE);
    endfunction

endpackage

// File: rtl/stk_chain.sv
module stk_chain
    import stk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  chain_op_t        op,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] top_word
);

    localparam int LAST = DEPTH - 1;

    logic [WIDTH-1:0] stage_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            logic [WIDTH-1:0] from_above;
            logic [WIDTH-1:0] from_below;
            logic [WIDTH-1:0] load_src;

            if (i == 0) begin : g_top
                assign from_above = '0;
                assign load_src   = load_word;
            end else begin : g_inner
                assign from_above = stage_q[i-1];
                assign load_src   = stage_q[i];
            end

            if (i == LAST) begin : g_bottom
                assign from_below = '0;
            end else begin : g_upper
                assign from_below = stage_q[i+1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[i] <= '0;
                end else begin
                    unique case (op)
                        OP_DEEPER: stage_q[i] <= from_above;
                        OP_UPWARD: stage_q[i] <= from_below;
                        OP_LOAD:   stage_q[i] <= load_src;
                        default:   stage_q[i] <= stage_q[i];
                    endcase
                end
            end
        end
    endgenerate

    assign top_word = stage_q[0];

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] push_data,
    output chain_op_t        op,
    output logic [WIDTH-1:0] load_word,
    output logic             full,
    output logic             empty,
    output logic             busy,
    output logic             err
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    ctrl_state_t      state_q, state_d;
    logic [CW-1:0]    count_q, count_d;
    logic [WIDTH-1:0] held_q;
    logic             err_q, err_d;
    logic             push_ok, pop_ok;

    assign full  = (count_q == CNT_MAX);
    assign empty = (count_q == '0);
    assign busy  = state_is_busy(state_q);

    // push has priority over pop when both are raised
    assign push_ok = !busy && push_req && !full;
    assign pop_ok  = !busy && !push_req && pop_req && !empty;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        err_d   = 1'b0;
        op      = OP_HOLD;
        unique case (state_q)
            ST_SHIFT: begin
                op      = OP_DEEPER;
                state_d = ST_LOAD;
            end
            ST_LOAD: begin
                op      = OP_LOAD;
                state_d = ST_IDLE;
            end
            default: begin
                if (push_ok) begin
                    state_d = ST_SHIFT;
                    count_d = count_q + 1'b1;
                end else if (pop_ok) begin
                    op      = OP_UPWARD;
                    count_d = count_q - 1'b1;
                end else if (push_req || pop_req) begin
                    err_d = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            held_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            err_q   <= err_d;
            if (push_ok) begin
                held_q <= push_data;
            end
        end
    end

    assign load_word = held_q;
    assign err       = err_q;

endmodule

// File: rtl/stk_lifo.sv
module stk_lifo
    import stk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data,
    output logic             full,
    output logic             empty,
    output logic             busy,
    output logic             err
);

    chain_op_t        op;
    logic [WIDTH-1:0] load_word;

    stk_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .op        (op),
        .load_word (load_word),
        .full      (full),
        .empty     (empty),
        .busy      (busy),
        .err       (err)
    );

    stk_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_chain (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_word (load_word),
        .top_word  (top_data)
    );

endmodule

// File: rtl/stk_lifo_chk.sv
module stk_lifo_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             push_req,
    input logic             pop_req,
    input logic [WIDTH-1:0] top_data,
    input logic             full,
    input logic             empty,
    input logic             busy,
    input logic             err
);

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    p_push_starts_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && push_req && !full) |=> busy);

    p_busy_two_cycles_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |=> busy);

    p_busy_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    p_busy_ignores_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(full) && $stable(empty) && !err));

    p_full_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && push_req && full) |=> (err && full && !busy && $stable(top_data)));

    p_empty_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !push_req && pop_req && empty) |=> (err && empty && !busy));

    p_push_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && push_req && pop_req && !full) |=> (busy && !err));

endmodule

bind stk_lifo stk_lifo_chk #(.WIDTH(WIDTH)) i_stk_lifo_chk (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .top_data (top_data),
    .full     (full),
    .empty    (empty),
    .busy     (busy),
    .err      (err)
);

// File: tb/test_stk_lifo.sv
`timescale 1ns/1ps
module test_stk_lifo;

    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_req = 1'b0;
    logic             pop_req = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic [WIDTH-1:0] top_data;
    logic             full, empty, busy, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stk_lifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_stk_lifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .top_data  (top_data),
        .full      (full),
        .empty     (empty),
        .busy      (busy),
        .err       (err)
    );

    // behavioural reference: queue with index 0 as top, padded to DEPTH with zeros
    int m_stk[$];
    int m_cnt;
    int m_phase;
    int m_pend;
    bit m_err;

    always @(posedge clk) begin
        if (rst) begin
            m_stk = {};
            for (int i = 0; i < DEPTH; i++) m_stk.push_back(0);
            m_cnt = 0;
            m_phase = 0;
            m_pend = 0;
            m_err = 1'b0;
        end else begin
            m_err = 1'b0;
            if (m_phase == 1) begin
                m_stk.push_front(0);
                void'(m_stk.pop_back());
                m_phase = 2;
            end else if (m_phase == 2) begin
                m_stk[0] = m_pend;
                m_phase = 0;
            end else if (push_req) begin
                if (m_cnt == DEPTH) m_err = 1'b1;
                else begin
                    m_pend = int'(push_data);
                    m_cnt++;
                    m_phase = 1;
                end
            end else if (pop_req) begin
                if (m_cnt == 0) m_err = 1'b1;
                else begin
                    void'(m_stk.pop_front());
                    m_stk.push_back(0);
                    m_cnt--;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(int'(top_data) == m_stk[0], "R2/R5 top_data", int'(top_data), m_stk[0]);
            check(full == (m_cnt == DEPTH), "R6 full", int'(full), int'(m_cnt == DEPTH));
            check(empty == (m_cnt == 0), "R6 empty", int'(empty), int'(m_cnt == 0));
            check(busy == (m_phase != 0), "R3/R4 busy", int'(busy), int'(m_phase != 0));
            check(err == m_err, "R7/R8 err", int'(err), int'(m_err));
        end
    end

    task automatic drive(input bit p, input bit q, input int d);
        @(negedge clk);
        push_req  = p;
        pop_req   = q;
        push_data = WIDTH'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0);
    endtask

    task automatic do_push(input int d);
        drive(1, 0, d);
        idle(2);
    endtask

    initial begin
        int exp_pop;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(empty == 1'b1, "R1 empty", int'(empty), 1);
        check(full == 1'b0, "R1 full", int'(full), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(err == 1'b0, "R1 err", int'(err), 0);
        check(top_data == '0, "R1 top", int'(top_data), 0);
        rst = 1'b0;

        // R3 push timing
        drive(1, 0, 8'h11);
        @(negedge clk);
        check(busy == 1'b1, "R3 busy cycle 1", int'(busy), 1);
        push_req = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R3 busy cycle 2", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R3 busy released", int'(busy), 0);
        check(top_data == 8'h11, "R3 top after push", int'(top_data), 8'h11);
        do_push(8'h22);
        do_push(8'h33);

        // R2 LIFO order; value visible in the pop cycle
        exp_pop = 8'h33;
        for (int k = 0; k < 3; k++) begin
            drive(0, 1, 0);
            #1;
            check(int'(top_data) == exp_pop, "R2 pop order", int'(top_data), exp_pop);
            exp_pop -= 8'h11;
        end
        drive(0, 0, 0);
        #1;
        check(empty == 1'b1, "R6 empty after drain", int'(empty), 1);

        // R8 pop when empty
        drive(0, 1, 0);
        drive(0, 0, 0);
        #1;
        check(err == 1'b1, "R8 err pulse", int'(err), 1);
        check(empty == 1'b1, "R8 still empty", int'(empty), 1);
        drive(0, 0, 0);
        #1;
        check(err == 1'b0, "R8 pulse one cycle", int'(err), 0);

        // fill to capacity
        for (int k = 1; k <= DEPTH; k++) do_push(8'hA0 + k);
        drive(0, 0, 0);
        #1;
        check(full == 1'b1, "R6 full at DEPTH", int'(full), 1);

        // R7 push when full
        drive(1, 0, 8'h5A);
        drive(0, 0, 0);
        #1;
        check(err == 1'b1, "R7 err pulse", int'(err), 1);
        check(busy == 1'b0, "R7 no busy", int'(busy), 0);
        check(int'(top_data) == 8'hA0 + DEPTH, "R7 top unchanged", int'(top_data), 8'hA0 + DEPTH);

        // R5 drain full stack; bottom fills with zero
        for (int k = 0; k < DEPTH; k++) drive(0, 1, 0);
        drive(0, 0, 0);
        #1;
        check(top_data == '0, "R5 zero after drain", int'(top_data), 0);

        // R4 requests during busy are ignored
        drive(1, 0, 8'h44);
        drive(1, 1, 8'h99);
        drive(0, 1, 0);
        drive(0, 0, 0);
        #1;
        check(top_data == 8'h44, "R4 top after busy requests", int'(top_data), 8'h44);
        check(full == 1'b0 && empty == 1'b0, "R4 one word held", int'({full, empty}), 0);

        // R9 push wins over pop
        drive(1, 1, 8'h55);
        idle(2);
        drive(0, 0, 0);
        #1;
        check(top_data == 8'h55, "R9 push performed", int'(top_data), 8'h55);

        // random stream compared every clock against the model
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom_range(0, 3));
            drive(r[0], r[1], int'($urandom_range(0, 255)));
        end
        idle(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule